// File: doc/BRIEF.md
# Stereo PCM Byte-Pair Assembler with Sample FIFO

This block sits behind a byte-wide, write-only host register. While the playback-mode input is high, the host writes each stereo sample pair as four bytes in a fixed order: left low, left high, right low, right high. The block joins those bytes into one left/right pair of 16-bit samples. On the fourth byte it pushes the pair into a small FIFO. The audio output side takes pairs out of the FIFO one at a time through a valid/ready handshake.

A two-bit position counter tracks where the host is within the four-byte group. When the mode input goes low, the counter returns to the first position. This means a group that was cut off cannot shift the bytes of the next group. If the FIFO is full when a fourth byte arrives, that pair is discarded and a sticky overflow flag is raised. The flag stays set until the host pulses a clear strobe. The host port has no read path.

Top module: `pcm_pair_fifo`

## Requirements
- R1: After reset, empty is 1, full is 0, overflow is 0 and out_valid is 0.
- R2: A byte write made while mode_en is 0 is ignored. It adds no pair and does not advance the byte position.
- R3: With mode_en at 1, four writes in the order left-low, left-high, right-low, right-high produce one pair with out_left = {byte2, byte1} and out_right = {byte4, byte3}.
- R4: No pair becomes visible before the fourth byte of a group. After one to three bytes, out_valid stays 0 and empty stays 1.
- R5: Dropping mode_en to 0 for at least one cycle returns the byte position to the first slot. The next four writes form a complete pair on their own.
- R6: The FIFO holds DEPTH pairs (default 8) and returns them in write order. full is 1 exactly when DEPTH pairs are stored, and empty is 1 exactly when none are stored.
- R7: A fourth-byte write while full is 1 is dropped without changing the stored pairs, and it sets overflow to 1.
- R8: overflow stays 1 until ovf_clr is pulsed, and then reads 0.
- R9: A pair leaves the FIFO only on a clock edge where out_valid and out_ready are both 1. While out_ready is 0, out_valid, out_left and out_right hold their values. out_ready while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en | input | 1 | PCM playback mode enable; low resets the byte position |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| out_ready | input | 1 | Output side accepts the head pair |
| out_valid | output | 1 | A pair is available |
| out_left | output | 16 | Left sample of the head pair |
| out_right | output | 16 | Right sample of the head pair |
| full | output | 1 | FIFO holds DEPTH pairs |
| empty | output | 1 | FIFO holds no pairs |
| overflow | output | 1 | Sticky: a pair was dropped because the FIFO was full |

## Verification
Each byte in a group gets a distinct value, so a swapped lane or a swapped channel shows up in the output words. Writes made with the mode off, and groups cut off by a mode drop, show whether the position counter ignores and resets as required. A sequence numbered across the full depth separates FIFO ordering and pointer wrap errors from a wrong full threshold. An extra group written into a full FIFO shows whether overflow drops the pair and leaves the stored data untouched. Holding the output stalled, and asserting ready on an empty FIFO, show whether pairs leave only on a real handshake.

// File: rtl/pcm_pair_fifo.sv
module pcm_pair_fifo #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_en,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        ovf_clr,
  input  logic        out_ready,
  output logic        out_valid,
  output logic [15:0] out_left,
  output logic [15:0] out_right,
  output logic        full,
  output logic        empty,
  output logic        overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]    pos;
  logic [7:0]    l_lo, l_hi, r_lo;
  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire take = mode_en & wr_en;
  wire last = take & (pos == 2'd3);
  wire push = last & ~full;
  wire pop  = out_valid & out_ready;

  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
  assign out_valid = ~empty;
  assign out_left  = mem[rp][31:16];
  assign out_right = mem[rp][15:0];

  always_ff @(posedge clk) begin
    if (!rst_n || !mode_en) pos <= 2'd0;
    else if (take)          pos <= pos + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      case (pos)
        2'd0:    l_lo <= wr_data;
        2'd1:    l_hi <= wr_data;
        2'd2:    r_lo <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {l_hi, l_lo, wr_data, r_lo};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          overflow <= 1'b0;
    else if (last & full) overflow <= 1'b1;
    else if (ovf_clr)    overflow <= 1'b0;
  end
endmodule

// File: rtl/pcm_pair_fifo_chk.sv
module pcm_pair_fifo_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_en,
  input logic        wr_en,
  input logic        ovf_clr,
  input logic        out_ready,
  input logic        out_valid,
  input logic [15:0] out_left,
  input logic [15:0] out_right,
  input logic        full,
  input logic        empty,
  input logic        overflow
);
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !empty); // R6

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_left) && $stable(out_right)); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !ovf_clr |=> overflow); // R8

  AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(full)); // R7

  AST_NO_PUSH_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(mode_en) && $past(wr_en)); // R2
endmodule

bind pcm_pair_fifo pcm_pair_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .wr_en(wr_en), .ovf_clr(ovf_clr),
  .out_ready(out_ready), .out_valid(out_valid), .out_left(out_left),
  .out_right(out_right), .full(full), .empty(empty), .overflow(overflow)
);

// File: tb/pcm_pair_fifo_bench.sv
module pcm_pair_fifo_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        ovf_clr = 1'b0;
  logic        out_ready = 1'b0;
  logic        out_valid, full, empty, overflow;
  logic [15:0] out_left, out_right;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pcm_pair_fifo #(.DEPTH(DEPTH)) u_pcm_pair_fifo (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .wr_en(wr_en), .wr_data(wr_data),
    .ovf_clr(ovf_clr), .out_ready(out_ready), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right), .full(full), .empty(empty),
    .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_pair(input logic [15:0] l, input logic [15:0] r);
    wr_byte(l[7:0]);
    wr_byte(l[15:8]);
    wr_byte(r[7:0]);
    wr_byte(r[15:8]);
  endtask

  task automatic pop_check(input logic [15:0] l, input logic [15:0] r, input string req);
    @(negedge clk);
    check(out_valid == 1'b1, req, {31'd0, out_valid}, 32'd1);
    check({out_left, out_right} == {l, r}, req, {out_left, out_right}, {l, r});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(empty && !full && !overflow && !out_valid, "R1",
          {28'd0, empty, full, overflow, out_valid}, 32'h8);
  endtask

  task automatic t_order;
    mode_en = 1'b1;
    wr_byte(8'h34);
    wr_byte(8'h12);
    wr_byte(8'h78);
    check(!out_valid && empty, "R4", {30'd0, out_valid, empty}, 32'h1);
    wr_byte(8'h56);
    pop_check(16'h1234, 16'h5678, "R3");
    check(empty, "R3", {31'd0, empty}, 32'd1);
  endtask

  task automatic t_mode_off;
    mode_en = 1'b0;
    wr_pair(16'hdead, 16'hbeef);
    wr_byte(8'h11);
    check(empty && !out_valid, "R2", {30'd0, empty, out_valid}, 32'h2);
    mode_en = 1'b1;
    wr_pair(16'hA1B2, 16'hC3D4);
    pop_check(16'hA1B2, 16'hC3D4, "R2");
  endtask

  task automatic t_seq_reset;
    mode_en = 1'b1;
    wr_byte(8'h99);
    wr_byte(8'h88);
    @(negedge clk);
    mode_en = 1'b0;
    @(negedge clk);
    mode_en = 1'b1;
    check(empty, "R5", {31'd0, empty}, 32'd1);
    wr_pair(16'h0F1E, 16'h2D3C);
    pop_check(16'h0F1E, 16'h2D3C, "R5");
    check(empty, "R5", {31'd0, empty}, 32'd1);
  endtask

  task automatic t_fill_overflow;
    mode_en = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      check(!full, "R6", {31'd0, full}, 32'd0);
      wr_pair(16'h1000 + 16'(i), 16'h2000 + 16'(i));
    end
    @(negedge clk);
    check(full && !empty, "R6", {30'd0, full, empty}, 32'h2);
    check(!overflow, "R7", {31'd0, overflow}, 32'd0);
    wr_pair(16'hFFFF, 16'hEEEE);
    @(negedge clk);
    check(overflow && full, "R7", {30'd0, overflow, full}, 32'h3);
    for (int i = 0; i < DEPTH; i++)
      pop_check(16'h1000 + 16'(i), 16'h2000 + 16'(i), "R6/R7 order");
    @(negedge clk);
    check(empty, "R7", {31'd0, empty}, 32'd1);
    check(overflow, "R8", {31'd0, overflow}, 32'd1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    @(negedge clk);
    check(!overflow, "R8", {31'd0, overflow}, 32'd0);
  endtask

  task automatic t_handshake;
    mode_en = 1'b1;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    out_ready = 1'b0;
    check(empty, "R9", {31'd0, empty}, 32'd1);
    wr_pair(16'h5A5A, 16'hA5A5);
    wr_pair(16'h0101, 16'h0202);
    repeat (4) @(negedge clk);
    check(out_valid && out_left == 16'h5A5A && out_right == 16'hA5A5, "R9",
          {out_left, out_right}, 32'h5A5AA5A5);
    pop_check(16'h5A5A, 16'hA5A5, "R9");
    pop_check(16'h0101, 16'h0202, "R9");
    @(negedge clk);
    check(empty, "R9", {31'd0, empty}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_order();
    t_mode_off();
    t_seq_reset();
    t_fill_overflow();
    t_handshake();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule